// File: doc/BRIEF.md
# Keyed Sleep and Wake Controller

This block decides when a small controller runs, naps or sleeps deeply. Three states are visible to the rest of the chip. In the running state everything is clocked. In the light-sleep state only the processor clock is stopped, so all register contents stay where they are. In the deep-sleep state the main oscillator is also switched off, while storage keeps its contents. Software cannot enter either sleep state with a single stray store. It must first arm a mode register and then, as its very next register write, store the unlock value 55h into a separate key register.

The block runs from an always-on clock. Wake requests come from three sources: port pins, each with its own enable, that sit at a low level; a strobe from the wake timer; and activity on the USB bus. From light sleep, a wake request returns the block to the running state on the next edge. From deep sleep, the oscillator is turned back on and a resume counter starts, with a delay chosen by the source. When the counter ends, a one-cycle resume-reset pulse is issued. A sticky cause register records which source did the waking. Hardware reset always returns the block to the running state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state code is 0 (run), `cpu_clk_en`, `osc_en` and `wdt_clk_en` are 1, `resume_rst` is 0 and `wake_cause` is 0.
- R2: A write of a value with bit 0 = 1 and bit 1 = 0 to the mode register (`wr_sel` = 0), followed by a next write of 55h to the key register (`wr_sel` = 1), enters light sleep (state code 1) at the key write's edge. In light sleep `cpu_clk_en` = 0 and `osc_en` = 1.
- R3: The same sequence with mode bit 1 = 1 enters deep sleep (state code 2), where `cpu_clk_en` = 0 and `osc_en` = 0. Bit 1 takes precedence when both bits are 1.
- R4: The armed mode is lost on any write other than the one that immediately follows it. This covers a key write with a value other than 55h, a write to the cause register (`wr_sel` = 2), and a write to the unused select 3. A key write of 55h that is not immediately preceded by an arming mode write leaves the block running.
- R5: `wdt_clk_en` is 1 in run, equals `wdt_idle_en` in light sleep, and is 0 in deep sleep and during the resume delay.
- R6: Pin i requests a wake when `pin_wake_en[i]` = 1 and `pin_in[i]` has been low for NSYNC synchronizer stages. A low pin whose enable is 0 has no effect.
- R7: In deep sleep, a wake request moves the block to the resume state (code 3, `osc_en` = 1) on the detecting edge. `resume_rst` then rises D+1 edges later for exactly one cycle, and the block re-enters run. D is PORT_DLY for a pin, TMR_DLY for `wake_tmr_done`, and USB_DLY for `usb_active`.
- R8: USB_DLY defaults to 16200 cycles, which is about 2.7 ms of a 6 MHz always-on clock.
- R9: In light sleep, any wake request returns the block to run on the next edge without a `resume_rst` pulse.
- R10: `wake_cause` has bit 0 = pin, bit 1 = timer and bit 2 = USB. A wake from either sleep state sets a single bit, with pin taking priority over timer and timer over USB. A write to select 2 clears each bit whose data bit is 0 and leaves each bit whose data bit is 1. Wake inputs received while running or resuming set no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one per write |
| wr_sel | input | 2 | 0 mode, 1 key, 2 wake cause, 3 unused |
| wr_data | input | 8 | Write data |
| wdt_idle_en | input | 1 | Keep watchdog clock in light sleep |
| pin_in | input | NPINS | Port pin levels |
| pin_wake_en | input | NPINS | Per-pin wake enables |
| wake_tmr_done | input | 1 | Wake-timer timeout strobe |
| usb_active | input | 1 | USB bus non-idle indication |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| resume_rst | output | 1 | One-cycle resume reset |
| wake_cause | output | 3 | Sticky wake source record |
| pm_state | output | 2 | State code: 0 run, 1 light, 2 deep, 3 resume |

## Verification
The case that is hardest to reach is a low pin with its enable cleared while the block is in deep sleep. From the ports it looks exactly like nothing happening. The bench therefore sweeps every enable mask against every single low pin. For each combination it confirms whether the oscillator stays off. When it stays off, the bench releases the block with a timer strobe and checks that the cause register names the timer and not the pin. The resume delay is also counted edge by edge for each source.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_KEY   = 2'd1;
  localparam logic [1:0] SEL_CAUSE = 2'd2;

  localparam int CAUSE_W  = 3;
  localparam int CZ_PIN   = 0;
  localparam int CZ_TMR   = 1;
  localparam int CZ_USB   = 2;
endpackage

// File: rtl/pwr_entry_guard.sv
module pwr_entry_guard
  import pwr_mode_pkg::*;
#(
  parameter logic [7:0] UNLOCK = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       allow,
  output logic       go_idle,
  output logic       go_down
);
  logic [1:0] armed_q;
  logic       key_hit;

  // Armed bits live for exactly one following write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 2'b00;
    end else if (wr_en) begin
      if (wr_sel == SEL_MODE) armed_q <= wr_data[1:0];
      else                    armed_q <= 2'b00;
    end
  end

  always_comb begin
    key_hit = wr_en && (wr_sel == SEL_KEY) && (wr_data == UNLOCK);
    go_down = key_hit && armed_q[1] && allow;
    go_idle = key_hit && armed_q[0] && !armed_q[1] && allow;
  end

  // R4
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_idle && go_down));

  // R4
  stale_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_MODE) |=> !(go_idle || go_down));
endmodule

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int NPINS = 8,
  parameter int NSYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pin_wake_en,
  output logic             pin_evt
);
  logic [NPINS-1:0] pin_sync;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [NSYNC-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '1;
      else if (NSYNC == 1) stage_q <= pin_in[p];
      else stage_q <= {stage_q[NSYNC-2:0], pin_in[p]};
    end
    assign pin_sync[p] = stage_q[NSYNC-1];
  end

  assign pin_evt = |(~pin_sync & pin_wake_en);
endmodule

// File: rtl/pwr_resume_timer.sv
module pwr_resume_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          fin
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= load;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fin = busy && (cnt_q == '0);

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

  // R7
  fin_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !busy);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int NSYNC    = 2,
  parameter int PORT_DLY = 64,
  parameter int TMR_DLY  = 64,
  parameter int USB_DLY  = 16200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               wdt_idle_en,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [NPINS-1:0]   pin_wake_en,
  input  logic               wake_tmr_done,
  input  logic               usb_active,
  output logic               cpu_clk_en,
  output logic               osc_en,
  output logic               wdt_clk_en,
  output logic               resume_rst,
  output logic [CAUSE_W-1:0] wake_cause,
  output logic [1:0]         pm_state
);
  localparam int DMAX0 = (PORT_DLY > TMR_DLY) ? PORT_DLY : TMR_DLY;
  localparam int DMAX  = (DMAX0 > USB_DLY) ? DMAX0 : USB_DLY;
  localparam int CW    = $clog2(DMAX + 1);

  pm_state_e           state_q;
  logic                go_idle, go_down;
  logic                pin_evt;
  logic                tmr_busy, tmr_fin, tmr_start;
  logic [CW-1:0]       tmr_load;
  logic [CAUSE_W-1:0]  pick, cause_q, cause_set;
  logic                any_wake, sleeping;

  pwr_entry_guard u_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .allow(state_q == PM_RUN),
    .go_idle(go_idle), .go_down(go_down)
  );

  pwr_wake_sync #(.NPINS(NPINS), .NSYNC(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .pin_wake_en(pin_wake_en), .pin_evt(pin_evt)
  );

  pwr_resume_timer #(.CW(CW)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
    .busy(tmr_busy), .fin(tmr_fin)
  );

  // Fixed priority: pin, then timer, then USB.
  always_comb begin
    pick = '0;
    if (pin_evt)            pick[CZ_PIN] = 1'b1;
    else if (wake_tmr_done) pick[CZ_TMR] = 1'b1;
    else if (usb_active)    pick[CZ_USB] = 1'b1;
    any_wake  = |pick;
    sleeping  = (state_q == PM_IDLE) || (state_q == PM_DOWN);
    cause_set = sleeping ? pick : '0;
    tmr_start = (state_q == PM_DOWN) && any_wake;
    if (pick[CZ_PIN])      tmr_load = CW'(PORT_DLY);
    else if (pick[CZ_TMR]) tmr_load = CW'(TMR_DLY);
    else                   tmr_load = CW'(USB_DLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PM_RUN;
      resume_rst <= 1'b0;
    end else begin
      resume_rst <= 1'b0;
      unique case (state_q)
        PM_RUN: begin
          if (go_down)      state_q <= PM_DOWN;
          else if (go_idle) state_q <= PM_IDLE;
        end
        PM_IDLE: if (any_wake) state_q <= PM_RUN;
        PM_DOWN: if (any_wake) state_q <= PM_WAKE;
        PM_WAKE: begin
          if (tmr_fin) begin
            state_q    <= PM_RUN;
            resume_rst <= 1'b1;
          end
        end
        default: state_q <= PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (wr_en && wr_sel == SEL_CAUSE) begin
      cause_q <= (cause_q & wr_data[CAUSE_W-1:0]) | cause_set;
    end else begin
      cause_q <= cause_q | cause_set;
    end
  end

  always_comb begin
    cpu_clk_en = (state_q == PM_RUN);
    osc_en     = (state_q != PM_DOWN);
    unique case (state_q)
      PM_RUN:  wdt_clk_en = 1'b1;
      PM_IDLE: wdt_clk_en = wdt_idle_en;
      default: wdt_clk_en = 1'b0;
    endcase
  end

  assign wake_cause = cause_q;
  assign pm_state   = state_q;

  // R3
  key_before_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DOWN && $past(state_q) == PM_RUN) |->
      $past(wr_en && wr_sel == SEL_KEY && wr_data == 8'h55));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst |=> !resume_rst);

  // R7
  rst_from_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst |-> (cpu_clk_en && $past(state_q) == PM_WAKE));

  // R7
  wake_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE && $past(state_q) == PM_WAKE) |-> tmr_busy);

  // R9
  idle_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE) |=> !resume_rst);

  // R6
  osc_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && $past(!osc_en)) |-> $past(any_wake));

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int NPINS = 4;
  localparam int NSYNC = 2;
  localparam int PD    = 3;
  localparam int TD    = 5;
  localparam int UD    = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wdt_idle_en = 1'b0;
  logic [NPINS-1:0] pin_in = '1;
  logic [NPINS-1:0] pin_wake_en = '0;
  logic       wake_tmr_done = 1'b0;
  logic       usb_active = 1'b0;
  logic       cpu_clk_en, osc_en, wdt_clk_en, resume_rst;
  logic [2:0] wake_cause;
  logic [1:0] pm_state;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.NPINS(NPINS), .NSYNC(NSYNC), .PORT_DLY(PD),
                  .TMR_DLY(TD), .USB_DLY(UD)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wdt_idle_en(wdt_idle_en), .pin_in(pin_in),
    .pin_wake_en(pin_wake_en), .wake_tmr_done(wake_tmr_done),
    .usb_active(usb_active), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .wdt_clk_en(wdt_clk_en), .resume_rst(resume_rst),
    .wake_cause(wake_cause), .pm_state(pm_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter(input logic [7:0] bits);
    wr(2'd0, bits);
    wr(2'd1, 8'h55);
  endtask

  task automatic pulse_tmr();
    wake_tmr_done = 1'b1; @(negedge clk); wake_tmr_done = 1'b0;
  endtask

  // Counts edges from the stimulus edge until resume_rst is seen high.
  task automatic measure(input int src, input int exp, input string req);
    int n = 0;
    bit seen = 1'b0;
    if (src == 0) pin_in[1] = 1'b0;
    if (src == 1) wake_tmr_done = 1'b1;
    if (src == 2) usb_active = 1'b1;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      wake_tmr_done = 1'b0; usb_active = 1'b0;
      if (resume_rst) seen = 1'b1;
    end
    chk(seen && n == exp, req, n, exp);
    @(negedge clk);
    chk(resume_rst == 1'b0 && cpu_clk_en, req, int'(resume_rst), 0);
    pin_in = '1;
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(pm_state == 2'd0 && cpu_clk_en && osc_en && wdt_clk_en && !resume_rst,
        "R1", int'(pm_state), 0);
    chk(wake_cause == 3'd0, "R1", int'(wake_cause), 0);

    // R2 light sleep entry, R5 watchdog off, R9 wake by timer
    wdt_idle_en = 1'b0;
    enter(8'h01);
    chk(pm_state == 2'd1 && !cpu_clk_en && osc_en, "R2", int'(pm_state), 1);
    chk(wdt_clk_en == 1'b0, "R5", int'(wdt_clk_en), 0);
    wdt_idle_en = 1'b1; #1;
    chk(wdt_clk_en == 1'b1, "R5", int'(wdt_clk_en), 1);
    pulse_tmr();
    chk(pm_state == 2'd0 && cpu_clk_en && !resume_rst, "R9", int'(pm_state), 0);
    chk(wake_cause == 3'b010, "R10", int'(wake_cause), 2);
    wr(2'd2, 8'h00);
    chk(wake_cause == 3'b000, "R10", int'(wake_cause), 0);

    // R9 USB wake from light sleep
    enter(8'h01);
    usb_active = 1'b1; @(negedge clk); usb_active = 1'b0;
    chk(pm_state == 2'd0 && !resume_rst && wake_cause == 3'b100, "R9", int'(wake_cause), 4);
    wr(2'd2, 8'h00);

    // R4 guard sequences
    wr(2'd0, 8'h01); wr(2'd1, 8'h54); wr(2'd1, 8'h55);
    chk(pm_state == 2'd0, "R4", int'(pm_state), 0);
    wr(2'd0, 8'h02); wr(2'd2, 8'hFF); wr(2'd1, 8'h55);
    chk(pm_state == 2'd0, "R4", int'(pm_state), 0);
    wr(2'd0, 8'h02); wr(2'd3, 8'h55); wr(2'd1, 8'h55);
    chk(pm_state == 2'd0, "R4", int'(pm_state), 0);
    wr(2'd1, 8'h55);
    chk(pm_state == 2'd0 && cpu_clk_en, "R4", int'(pm_state), 0);
    wr(2'd0, 8'h00); wr(2'd1, 8'h55);
    chk(pm_state == 2'd0, "R4", int'(pm_state), 0);

    // R3 deep sleep with both bits set, R5 watchdog off
    enter(8'h03);
    chk(pm_state == 2'd2 && !cpu_clk_en && !osc_en, "R3", int'(pm_state), 2);
    chk(wdt_clk_en == 1'b0, "R5", int'(wdt_clk_en), 0);
    // R10 inputs ignored in run: after wake, only timer bit
    measure(1, TD + 2, "R7 timer delay");
    chk(wake_cause == 3'b010, "R10", int'(wake_cause), 2);
    pulse_tmr(); usb_active = 1'b1; @(negedge clk); usb_active = 1'b0;
    chk(wake_cause == 3'b010, "R10 run ignore", int'(wake_cause), 2);

    // R7 pin delay and R10 per-bit clear
    pin_wake_en = 4'b0010;
    enter(8'h02);
    measure(0, PD + 2 + NSYNC, "R7 pin delay");
    chk(wake_cause == 3'b011, "R10", int'(wake_cause), 3);
    wr(2'd2, 8'b0000_0010);
    chk(wake_cause == 3'b010, "R10 clear", int'(wake_cause), 2);
    wr(2'd2, 8'h00);

    // R8 USB delay, resume state check
    enter(8'h02);
    usb_active = 1'b1; @(negedge clk); usb_active = 1'b0;
    chk(pm_state == 2'd3 && osc_en && !wdt_clk_en, "R7", int'(pm_state), 3);
    cyc(UD + 5);
    chk(pm_state == 2'd0 && wake_cause == 3'b100, "R8", int'(wake_cause), 4);
    wr(2'd2, 8'h00);
    enter(8'h02);
    measure(2, UD + 2, "R8 usb delay");
    wr(2'd2, 8'h00);

    // R10 priority timer over USB
    enter(8'h02);
    wake_tmr_done = 1'b1; usb_active = 1'b1; @(negedge clk);
    wake_tmr_done = 1'b0; usb_active = 1'b0;
    cyc(TD + 4);
    chk(wake_cause == 3'b010, "R10 priority", int'(wake_cause), 2);
    wr(2'd2, 8'h00);

    // R6 sweep: every enable mask against every single low pin
    for (int m = 0; m < (1 << NPINS); m++) begin
      for (int p = 0; p < NPINS; p++) begin
        pin_wake_en = NPINS'(m);
        enter(8'h02);
        pin_in[p] = 1'b0;
        cyc(NSYNC + 2);
        if (m[p]) begin
          chk(osc_en == 1'b1, "R6 enabled pin", int'(osc_en), 1);
          cyc(PD + 3);
          chk(wake_cause == 3'b001 && pm_state == 2'd0, "R6", int'(wake_cause), 1);
          pin_in = '1;
        end else begin
          chk(osc_en == 1'b0 && pm_state == 2'd2, "R6 masked pin", int'(osc_en), 0);
          pin_in = '1;
          pulse_tmr();
          cyc(TD + 3);
          chk(wake_cause == 3'b010 && pm_state == 2'd0, "R6 masked cause", int'(wake_cause), 2);
        end
        wr(2'd2, 8'h00);
        cyc(NSYNC);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule